// File: doc/BRIEF.md
# Dual-Space Address Pointer Controller

This block sits behind a serial two-wire slave front end and owns the addressing for two separate targets behind one bus port. The first target is a byte-wide memory. The second is a small companion register file with 25 entries. The front end delivers one event per byte. Each event carries the byte value, the target that the slave address selected, the transfer direction and the byte's position in the transaction. The controller turns these events into address, strobe and write-data signals for whichever target is selected. It also captures the byte to be shifted out on reads.

Each space keeps its own current-address latch, and that latch persists across transactions. Only the power-on reset clears it. The memory latch takes two address bytes, upper byte first, and keeps only the bits the configured memory density implements. The pointer steps once per data byte in the same cycle as the access, so the step lands before the acknowledge slot. It wraps from the top of memory to zero. The companion latch takes one address byte. A value beyond the last register raises an abort, and so does a burst that tries to step past the last register.

Top module: `addr_ptr_ctrl`

## Requirements
- R1: After power-on reset, mem_addr and reg_addr are 0, rd_data is 0, and abort and all four strobes are low.
- R2: Memory address loading uses write events (rd_nwr=0) with tgt_sel=0 (memory). A byte with byte_pos=00 is the upper address byte and changes nothing visible. The next byte, with byte_pos=01, loads mem_addr with {upper byte, lower byte} truncated to MEM_AW bits, so the upper bits above the density are dropped.
- R3: A memory write data event (byte_pos=10, rd_nwr=0) raises mem_we in the same cycle. In that cycle mem_addr shows the current pointer and mem_wdata equals byte_in. From the next cycle mem_addr is one higher.
- R4: A memory read data event (byte_pos=10, rd_nwr=1) raises mem_re in the same cycle at the current pointer. From the next cycle rd_data holds the mem_rdata of that cycle and mem_addr is one higher.
- R5: A memory data access at the highest address (2^MEM_AW-1) is performed normally, and the pointer then becomes 0.
- R6: Companion events (tgt_sel=1) never change mem_addr. At most one of mem_we, mem_re, reg_we and reg_re is high in any cycle.
- R7: A companion write event with byte_pos=00 is the register address. A value from 00h to 18h loads reg_addr with no abort. A higher value raises abort in that cycle and leaves reg_addr unchanged.
- R8: A companion data event (byte_pos=10) raises reg_we for a write or reg_re for a read, at the current reg_addr. A read captures reg_rdata into rd_data. Below 18h the pointer then steps by one.
- R9: A companion data event at reg_addr 18h still performs the access, raises abort in that cycle, and reg_addr stays 18h.
- R10: A memory address loaded without any data bytes is kept across later companion transactions, and the next memory read accesses exactly that address.
- R11: Without byte_vld no strobe rises and no pointer moves. The reserved position byte_pos=11 and address positions (00, 01) with rd_nwr=1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| byte_vld | input | 1 | One-cycle byte event from the bus front end |
| byte_in | input | 8 | Received byte (address or write data) |
| tgt_sel | input | 1 | Target space: 0 memory, 1 companion |
| rd_nwr | input | 1 | Direction: 1 read, 0 write |
| byte_pos | input | 2 | 00 first address byte, 01 second address byte, 10 data, 11 reserved |
| mem_rdata | input | 8 | Memory read data at mem_addr |
| reg_rdata | input | 8 | Register file read data at reg_addr |
| mem_addr | output | MEM_AW | Current memory pointer |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| reg_addr | output | REG_AW | Current companion register pointer |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_wdata | output | 8 | Register write data |
| rd_data | output | 8 | Byte captured for transmission on reads |
| abort | output | 1 | Illegal companion address; NACK and abort the transfer |

## Verification
Several properties are checked on every cycle. Each memory data access steps the pointer by one or wraps it at the top, and companion traffic never moves the memory pointer. The companion pointer never leaves the legal range and is frozen in any abort cycle. Strobes stay mutually exclusive and silent without an event, and read data is captured one cycle after a read strobe. The scenarios are the only way to show the concrete values. These include truncation of the upper address bits and the exact address a random read reaches after an interleaved companion transaction. They also cover the reserved and misdirected positions being ignored, and which companion address values are accepted or aborted.

// File: rtl/addr_ptr_pkg.sv
package addr_ptr_pkg;

    typedef enum logic [1:0] {
        POS_ADDR_HI = 2'b00,
        POS_ADDR_LO = 2'b01,
        POS_DATA    = 2'b10,
        POS_RSVD    = 2'b11
    } byte_pos_e;

endpackage

// File: rtl/mem_ptr_unit.sv
module mem_ptr_unit
    import addr_ptr_pkg::*;
#(
    parameter int MEM_AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              rd_nwr,
    input  byte_pos_e         pos,
    input  logic [7:0]        byte_in,
    output logic [MEM_AW-1:0] ptr,
    output logic              we,
    output logic              re
);
    localparam int HI_W = MEM_AW - 8;
    localparam logic [MEM_AW-1:0] TOP = {MEM_AW{1'b1}};

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [MEM_AW-1:0] ptr;
    } mem_state_t;

    mem_state_t st_d, st_q;
    logic load_hi, load_lo, access;

    always_comb begin
        load_hi = evt && !rd_nwr && (pos == POS_ADDR_HI);
        load_lo = evt && !rd_nwr && (pos == POS_ADDR_LO);
        access  = evt && (pos == POS_DATA);
        st_d    = st_q;
        if (load_hi) begin
            st_d.hi = byte_in[HI_W-1:0];
        end
        if (load_lo) begin
            st_d.ptr = {st_q.hi, byte_in};
        end else if (access) begin
            st_d.ptr = (st_q.ptr == TOP) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;
    assign we  = access && !rd_nwr;
    assign re  = access && rd_nwr;

    AST_MEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (access && st_q.ptr != TOP) |=> st_q.ptr == $past(st_q.ptr) + 1'b1); // R3
    AST_MEM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (access && st_q.ptr == TOP) |=> st_q.ptr == '0); // R5
    AST_MEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(st_q.ptr)); // R6
    AST_MEM_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_lo |=> st_q.ptr[7:0] == $past(byte_in)); // R2
endmodule

// File: rtl/reg_ptr_unit.sv
module reg_ptr_unit
    import addr_ptr_pkg::*;
#(
    parameter int REG_LAST = 24,
    parameter int REG_AW   = $clog2(REG_LAST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              rd_nwr,
    input  byte_pos_e         pos,
    input  logic [7:0]        byte_in,
    output logic [REG_AW-1:0] ptr,
    output logic              we,
    output logic              re,
    output logic              abort
);
    localparam logic [REG_AW-1:0] LAST_P = REG_AW'(REG_LAST);
    localparam logic [7:0]        LAST_B = 8'(REG_LAST);

    typedef struct packed {
        logic [REG_AW-1:0] ptr;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic load, access, bad_load, at_last;

    always_comb begin
        load     = evt && !rd_nwr && (pos == POS_ADDR_HI);
        access   = evt && (pos == POS_DATA);
        bad_load = load && (byte_in > LAST_B);
        at_last  = st_q.ptr == LAST_P;
        st_d     = st_q;
        if (load && !bad_load) begin
            st_d.ptr = byte_in[REG_AW-1:0];
        end else if (access && !at_last) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr   = st_q.ptr;
    assign we    = access && !rd_nwr;
    assign re    = access && rd_nwr;
    assign abort = bad_load || (access && at_last);

    AST_REG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ptr <= LAST_P); // R7
    AST_REG_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> $stable(st_q.ptr)); // R9
    AST_REG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !at_last) |=> st_q.ptr == $past(st_q.ptr) + 1'b1); // R8
endmodule

// File: rtl/addr_ptr_ctrl.sv
module addr_ptr_ctrl
    import addr_ptr_pkg::*;
#(
    parameter int MEM_AW   = 15,
    parameter int REG_LAST = 24,
    parameter int REG_AW   = $clog2(REG_LAST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              tgt_sel,
    input  logic              rd_nwr,
    input  logic [1:0]        byte_pos,
    input  logic [7:0]        mem_rdata,
    input  logic [7:0]        reg_rdata,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [7:0]        mem_wdata,
    output logic [REG_AW-1:0] reg_addr,
    output logic              reg_we,
    output logic              reg_re,
    output logic [7:0]        reg_wdata,
    output logic [7:0]        rd_data,
    output logic              abort
);
    typedef struct packed {
        logic [7:0] rd;
    } top_state_t;

    top_state_t st_d, st_q;
    byte_pos_e  pos;
    logic       mem_evt, reg_evt;

    assign pos     = byte_pos_e'(byte_pos);
    assign mem_evt = byte_vld && !tgt_sel;
    assign reg_evt = byte_vld && tgt_sel;

    mem_ptr_unit #(.MEM_AW(MEM_AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .evt(mem_evt), .rd_nwr(rd_nwr), .pos(pos),
        .byte_in(byte_in), .ptr(mem_addr), .we(mem_we), .re(mem_re)
    );

    reg_ptr_unit #(.REG_LAST(REG_LAST), .REG_AW(REG_AW)) u_reg (
        .clk(clk), .rst_n(rst_n), .evt(reg_evt), .rd_nwr(rd_nwr), .pos(pos),
        .byte_in(byte_in), .ptr(reg_addr), .we(reg_we), .re(reg_re), .abort(abort)
    );

    always_comb begin
        st_d = st_q;
        if (mem_re)      st_d.rd = mem_rdata;
        else if (reg_re) st_d.rd = reg_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.rd;
    assign mem_wdata = byte_in;
    assign reg_wdata = byte_in;

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |-> !(mem_we || mem_re || reg_we || reg_re || abort)); // R11
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re, reg_we, reg_re})); // R6
    AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> rd_data == $past(mem_rdata)); // R4
endmodule

// File: tb/tb_addr_ptr_ctrl.sv
module tb_addr_ptr_ctrl;
    localparam int MEM_AW = 15;
    localparam int REG_AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_vld = 1'b0;
    logic [7:0] byte_in = '0;
    logic tgt_sel = 1'b0;
    logic rd_nwr = 1'b0;
    logic [1:0] byte_pos = 2'b11;
    logic [7:0] mem_rdata, reg_rdata;
    logic [MEM_AW-1:0] mem_addr;
    logic [REG_AW-1:0] reg_addr;
    logic mem_we, mem_re, reg_we, reg_re, abort;
    logic [7:0] mem_wdata, reg_wdata, rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic c_mwe, c_mre, c_rwe, c_rre, c_abort;
    logic [MEM_AW-1:0] c_maddr;
    logic [REG_AW-1:0] c_raddr;
    logic [7:0] c_mwdata, c_rwdata;

    always #10 clk = ~clk;

    assign mem_rdata = mem_addr[7:0] ^ 8'hA5;
    assign reg_rdata = {3'b000, reg_addr} + 8'h40;

    addr_ptr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .tgt_sel(tgt_sel), .rd_nwr(rd_nwr), .byte_pos(byte_pos),
        .mem_rdata(mem_rdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
        .reg_wdata(reg_wdata), .rd_data(rd_data), .abort(abort)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(logic vld, logic tgt, logic rd, logic [1:0] pos, logic [7:0] b);
        @(negedge clk);
        byte_vld = vld; tgt_sel = tgt; rd_nwr = rd; byte_pos = pos; byte_in = b;
        #2;
        c_mwe = mem_we; c_mre = mem_re; c_rwe = reg_we; c_rre = reg_re;
        c_abort = abort; c_maddr = mem_addr; c_raddr = reg_addr;
        c_mwdata = mem_wdata; c_rwdata = reg_wdata;
        @(negedge clk);
        byte_vld = 1'b0; byte_pos = 2'b11;
        #2;
    endtask

    task automatic t_reset();
        chk("R1", "mem_addr", 32'(mem_addr), 0);
        chk("R1", "reg_addr", 32'(reg_addr), 0);
        chk("R1", "rd_data", 32'(rd_data), 0);
        chk("R1", "strobes+abort", 32'({mem_we, mem_re, reg_we, reg_re, abort}), 0);
    endtask

    task automatic t_mem_load();
        xfer(1, 0, 0, 2'b00, 8'hF2);
        chk("R2", "addr after upper byte", 32'(mem_addr), 0);
        xfer(1, 0, 0, 2'b01, 8'h34);
        chk("R2", "addr truncated", 32'(mem_addr), 32'h7234);
    endtask

    task automatic t_mem_write();
        xfer(1, 0, 0, 2'b10, 8'h5A);
        chk("R3", "mem_we", 32'(c_mwe), 1);
        chk("R3", "write addr", 32'(c_maddr), 32'h7234);
        chk("R3", "wdata", 32'(c_mwdata), 32'h5A);
        chk("R3", "abort quiet", 32'(c_abort), 0);
        chk("R3", "addr stepped", 32'(mem_addr), 32'h7235);
    endtask

    task automatic t_mem_read();
        xfer(1, 0, 1, 2'b10, 8'h00);
        chk("R4", "mem_re", 32'(c_mre), 1);
        chk("R4", "mem_we low", 32'(c_mwe), 0);
        chk("R4", "read addr", 32'(c_maddr), 32'h7235);
        chk("R4", "rd_data", 32'(rd_data), 32'h90);
        chk("R4", "addr stepped", 32'(mem_addr), 32'h7236);
    endtask

    task automatic t_wrap();
        xfer(1, 0, 0, 2'b00, 8'hFF);
        xfer(1, 0, 0, 2'b01, 8'hFF);
        chk("R5", "top addr", 32'(mem_addr), 32'h7FFF);
        xfer(1, 0, 0, 2'b10, 8'h11);
        chk("R5", "write at top", 32'(c_mwe), 1);
        chk("R5", "wrapped", 32'(mem_addr), 0);
        xfer(1, 0, 1, 2'b10, 8'h00);
        chk("R5", "read after wrap", 32'(rd_data), 32'hA5);
        chk("R5", "step after wrap", 32'(mem_addr), 1);
    endtask

    task automatic t_comp();
        xfer(1, 1, 0, 2'b00, 8'h10);
        chk("R7", "reg load", 32'(reg_addr), 32'h10);
        chk("R7", "no abort", 32'(c_abort), 0);
        chk("R6", "mem untouched", 32'(mem_addr), 1);
        xfer(1, 1, 0, 2'b10, 8'hC3);
        chk("R8", "reg_we", 32'(c_rwe), 1);
        chk("R8", "reg wr addr", 32'(c_raddr), 32'h10);
        chk("R8", "reg_wdata", 32'(c_rwdata), 32'hC3);
        chk("R6", "no mem strobe", 32'({c_mwe, c_mre}), 0);
        chk("R8", "reg stepped", 32'(reg_addr), 32'h11);
        xfer(1, 1, 1, 2'b10, 8'h00);
        chk("R8", "reg_re", 32'(c_rre), 1);
        chk("R8", "rd_data", 32'(rd_data), 32'h51);
        chk("R8", "reg stepped again", 32'(reg_addr), 32'h12);
        chk("R6", "mem still untouched", 32'(mem_addr), 1);
    endtask

    task automatic t_comp_bad();
        xfer(1, 1, 0, 2'b00, 8'h19);
        chk("R7", "abort 19h", 32'(c_abort), 1);
        chk("R7", "reg kept 19h", 32'(reg_addr), 32'h12);
        xfer(1, 1, 0, 2'b00, 8'hFF);
        chk("R7", "abort FFh", 32'(c_abort), 1);
        chk("R7", "reg kept FFh", 32'(reg_addr), 32'h12);
    endtask

    task automatic t_comp_edge();
        xfer(1, 1, 0, 2'b00, 8'h18);
        chk("R7", "18h accepted", 32'(c_abort), 0);
        chk("R7", "18h loaded", 32'(reg_addr), 32'h18);
        xfer(1, 1, 0, 2'b10, 8'h77);
        chk("R9", "access at last", 32'(c_rwe), 1);
        chk("R9", "abort at last", 32'(c_abort), 1);
        chk("R9", "reg holds last", 32'(reg_addr), 32'h18);
    endtask

    task automatic t_random_read();
        xfer(1, 0, 0, 2'b00, 8'h01);
        xfer(1, 0, 0, 2'b01, 8'h23);
        xfer(1, 1, 0, 2'b00, 8'h05);
        xfer(1, 1, 1, 2'b10, 8'h00);
        chk("R10", "kept over companion", 32'(mem_addr), 32'h0123);
        xfer(1, 0, 1, 2'b10, 8'h00);
        chk("R10", "read addr", 32'(c_maddr), 32'h0123);
        chk("R10", "read data", 32'(rd_data), 32'h86);
    endtask

    task automatic t_ignore();
        xfer(0, 0, 0, 2'b10, 8'h99);
        chk("R11", "no strobe w/o vld", 32'({c_mwe, c_mre, c_rwe, c_rre, c_abort}), 0);
        chk("R11", "mem held w/o vld", 32'(mem_addr), 32'h0124);
        xfer(1, 0, 0, 2'b11, 8'h99);
        chk("R11", "reserved pos strobes", 32'({c_mwe, c_mre}), 0);
        chk("R11", "reserved pos addr", 32'(mem_addr), 32'h0124);
        xfer(1, 0, 1, 2'b01, 8'h99);
        chk("R11", "read-dir addr byte", 32'(mem_addr), 32'h0124);
        xfer(1, 1, 1, 2'b00, 8'h02);
        chk("R11", "read-dir reg addr", 32'(reg_addr), 32'h06);
        chk("R11", "read-dir reg abort", 32'(c_abort), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        t_mem_load();
        t_mem_write();
        t_mem_read();
        t_wrap();
        t_comp();
        t_comp_bad();
        t_comp_edge();
        t_random_read();
        t_ignore();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule